// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block forms 20-bit physical addresses for a 1 MB memory space. It does so from a 16-bit offset and one of four 16-bit segment base registers. The registers cover code, data, stack and extra data, and each can be loaded through a write port. A caller asserts a request with a segment selector and an offset. One clock later the block presents the physical address, computed as the base shifted left by four bits plus the offset, together with a valid flag.

The block also owns a 16-bit stack pointer. A push strobe moves the pointer down by two and then addresses the new location. A pop strobe addresses the current location and then moves the pointer up by two. Stack accesses always use the stack base register, whatever the selector says. The block holds no 20-bit address register. Only 16-bit quantities are stored, and the physical address exists only in the output stage.

Top module: `seg_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `addr_valid` is 0, `phys_addr` is 0, and all four segment bases and the stack pointer are zero. A request issued right after reset therefore returns its bare offset.
- R2: When `req_valid` is 1 and no single stack strobe is active, `phys_addr` one cycle later equals (selected base × 16 + `req_off`) modulo 2^20, with `addr_valid` set to 1.
- R3: The selector encoding is 2'b00 for extra data, 2'b01 for code, 2'b10 for stack and 2'b11 for data. It applies to both `req_seg` and `seg_wr_sel`.
- R4: A segment write loads `seg_wr_data` into the register named by `seg_wr_sel` at the clock edge. A request in the same cycle as a write to the same register still sees the old value, and the next cycle sees the new one.
- R5: A push alone first lowers the stack pointer by 2. One cycle later it presents stack base × 16 + the lowered pointer, with `addr_valid` set to 1.
- R6: A pop alone presents stack base × 16 + the current pointer one cycle later, and then raises the pointer by 2. A pop after a push returns the address that the push produced.
- R7: When `push` and `pop` are both 1 in the same cycle, neither has any effect. The stack pointer is unchanged, and the cycle is treated as having no stack strobe.
- R8: A single stack strobe takes priority over `req_valid`. It uses the stack base (selector 2'b10) regardless of `req_seg`.
- R9: The physical address wraps at the top of the 1 MB space. For example, base 16'hFFFF with offset 16'h0010 gives 20'h00000.
- R10: The stack pointer wraps modulo 2^16. A push from pointer 0 addresses offset 16'hFFFE.
- R11: When there is neither a request nor a single stack strobe, `addr_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request strobe |
| req_seg | input | 2 | Segment selector for the request |
| req_off | input | 16 | Offset for the request |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| seg_wr_en | input | 1 | Segment base write enable |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | New segment base value |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | Physical address is valid |

## Verification
Each of the four selectors is loaded with a distinct base, so an address built from the wrong register has a different value from a correct one. Small and large offsets are paired with bases near the top of the space, which separates a correct 20-bit wrap from a carry that is lost or kept. Runs of pushes followed by pops, starting from pointer zero, distinguish decrement-before-use from use-before-increment and expose pointer wrap. Cycles that combine a write with a request, both strobes with a request, and a stack strobe with a request each isolate one ordering or priority rule. A long stretch of random traffic is then compared cycle by cycle against the model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W      = 16;
    localparam int OFF_W      = 16;
    localparam int PA_W       = 20;
    localparam int SEG_SHIFT  = PA_W - SEG_W;
    localparam int NUM_SEG    = 4;
    localparam int SEL_W      = $clog2(NUM_SEG);
    localparam int STACK_STEP = 2;

    typedef logic [SEG_W-1:0] seg_base_t;
    typedef logic [OFF_W-1:0] offset_t;
    typedef logic [PA_W-1:0]  phys_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_EXTRA = 2'b00,
        SEL_CODE  = 2'b01,
        SEL_STACK = 2'b10,
        SEL_DATA  = 2'b11
    } seg_sel_e;

    typedef struct packed {
        logic      valid;
        seg_base_t base;
        offset_t   off;
    } addr_src_t;

    function automatic phys_t form_phys(input seg_base_t b, input offset_t o);
        phys_t shifted;
        phys_t widened;
        shifted = PA_W'(b) << SEG_SHIFT;
        widened = PA_W'(o);
        return shifted + widened;
    endfunction
endpackage

// File: rtl/seg_base_file.sv
module seg_base_file
    import seg_addr_pkg::*;
#(
    parameter int N_REG     = NUM_SEG,
    parameter int REG_W     = SEG_W,
    parameter int STACK_IDX = int'(SEL_STACK),
    localparam int IDX_W    = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_base,
    output logic [REG_W-1:0] stk_base
);
    logic [REG_W-1:0] regs [N_REG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_REG; i++)
                if (wr_sel == IDX_W'(i)) regs[i] <= wr_data;
        end
    end

    assign rd_base  = regs[rd_sel];
    assign stk_base = regs[STACK_IDX];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import seg_addr_pkg::*;
#(
    parameter int PTR_W = OFF_W,
    parameter int STEP  = STACK_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic             stk_access,
    output logic [PTR_W-1:0] stk_off
);
    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

    logic [PTR_W-1:0] sp;
    logic             do_push;
    logic             do_pop;
    logic [PTR_W-1:0] sp_down;

    assign do_push    = push & ~pop;
    assign do_pop     = pop & ~push;
    assign sp_down    = sp - STEP_V;
    assign stk_access = do_push | do_pop;
    assign stk_off    = do_push ? sp_down : sp;

    always_ff @(posedge clk) begin
        if (rst)          sp <= '0;
        else if (do_push) sp <= sp_down;
        else if (do_pop)  sp <= sp + STEP_V;
    end

    assert_push_lowers_R5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> sp == $past(sp) - STEP_V);
    assert_pop_raises_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> sp == $past(sp) + STEP_V);
    assert_both_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(sp));
endmodule

// File: rtl/addr_out_stage.sv
module addr_out_stage
    import seg_addr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_src_t src,
    output phys_t     phys,
    output logic      valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phys  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= src.valid;
            if (src.valid) phys <= form_phys(src.base, src.off);
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SEL_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                push,
    input  logic                pop,
    input  logic                seg_wr_en,
    input  logic [SEL_W-1:0]    seg_wr_sel,
    input  logic [SEG_W-1:0]    seg_wr_data,
    output logic [PA_W-1:0]     phys_addr,
    output logic                addr_valid
);
    seg_base_t rd_base;
    seg_base_t stk_base;
    logic      stk_access;
    offset_t   stk_off;
    addr_src_t src;

    seg_base_file u_bases (
        .clk(clk), .rst(rst),
        .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_data(seg_wr_data),
        .rd_sel(req_seg), .rd_base(rd_base), .stk_base(stk_base)
    );

    stack_ptr_unit u_sp (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .stk_access(stk_access), .stk_off(stk_off)
    );

    always_comb begin
        src.valid = stk_access | req_valid;
        if (stk_access) begin
            src.base = stk_base;
            src.off  = stk_off;
        end else begin
            src.base = rd_base;
            src.off  = req_off;
        end
    end

    addr_out_stage u_out (
        .clk(clk), .rst(rst), .src(src),
        .phys(phys_addr), .valid(addr_valid)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!addr_valid && phys_addr == '0));
    assert_stack_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (push ^ pop) |=> addr_valid);
    assert_idle_invalid_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !(push ^ pop)) |=> !addr_valid);
    assert_request_valid_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);
endmodule

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
    logic        clk = 0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_seg;
    logic [15:0] req_off;
    logic        push, pop;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic [19:0] phys_addr;
    logic        addr_valid;

    int checks = 0;
    int errors = 0;

    int m_seg [4];
    int m_sp;

    always #5 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .push(push), .pop(pop), .seg_wr_en(seg_wr_en),
        .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .phys_addr(phys_addr), .addr_valid(addr_valid)
    );

    function automatic int pa(int b, int o);
        return (b * 16 + o) % 1048576;
    endfunction

    task automatic check(string tag, logic ev, int ea);
        checks++;
        if (addr_valid !== ev || (ev && phys_addr !== 20'(ea))) begin
            errors++;
            $display("FAIL %s: got valid=%0b addr=%05h, expected valid=%0b addr=%05h",
                     tag, addr_valid, phys_addr, ev, 20'(ea));
        end
    endtask

    task automatic step(string tag, logic rv, logic [1:0] rs, logic [15:0] ro,
                        logic pu, logic po, logic we, logic [1:0] ws, logic [15:0] wd);
        logic ev;
        int base, off;
        @(negedge clk);
        req_valid = rv; req_seg = rs; req_off = ro; push = pu; pop = po;
        seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
        ev = 0; base = 0; off = 0;
        if (pu ^ po) begin
            base = m_seg[2];
            if (pu) begin
                m_sp = (m_sp + 65536 - 2) % 65536;
                off = m_sp;
            end else begin
                off = m_sp;
                m_sp = (m_sp + 2) % 65536;
            end
            ev = 1;
        end else if (rv) begin
            base = m_seg[rs];
            off = ro;
            ev = 1;
        end
        if (we) m_seg[ws] = wd;
        @(posedge clk);
        #1;
        check(tag, ev, pa(base, off));
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_seg = 0; req_off = 0; push = 0; pop = 0;
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        for (int i = 0; i < 4; i++) m_seg[i] = 0;
        m_sp = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", 0, 0);
        @(negedge clk); rst = 0;

        // R1: zero bases after reset give bare offsets
        for (int s = 0; s < 4; s++) step("R1 zero base", 1, 2'(s), 16'h1234 + 16'(s), 0, 0, 0, 0, 0);
        // R11: idle
        step("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0);

        // R3/R4: load distinct bases by encoding
        step("R3 load extra", 0, 0, 0, 0, 0, 1, 2'b00, 16'h1000);
        step("R3 load code",  0, 0, 0, 0, 0, 1, 2'b01, 16'h2000);
        step("R3 load stack", 0, 0, 0, 0, 0, 1, 2'b10, 16'h3000);
        step("R3 load data",  0, 0, 0, 0, 0, 1, 2'b11, 16'h4000);
        // R2/R3: each selector
        step("R3 extra sel", 1, 2'b00, 16'h0005, 0, 0, 0, 0, 0);
        step("R3 code sel",  1, 2'b01, 16'h0ABC, 0, 0, 0, 0, 0);
        step("R3 stack sel", 1, 2'b10, 16'hFFFF, 0, 0, 0, 0, 0);
        step("R2 data sel",  1, 2'b11, 16'h8001, 0, 0, 0, 0, 0);

        // R4: same-cycle write and read sees old, next cycle new
        step("R4 old value", 1, 2'b01, 16'h0010, 0, 0, 1, 2'b01, 16'h5555);
        step("R4 new value", 1, 2'b01, 16'h0010, 0, 0, 0, 0, 0);

        // R9: wrap at 1 MB
        step("R9 load", 0, 0, 0, 0, 0, 1, 2'b11, 16'hFFFF);
        step("R9 wrap zero", 1, 2'b11, 16'h0010, 0, 0, 0, 0, 0);
        step("R9 wrap high", 1, 2'b11, 16'hFFFF, 0, 0, 0, 0, 0);

        // R10/R5/R6: stack from pointer zero
        step("R10 push wrap", 0, 0, 0, 1, 0, 0, 0, 0);
        step("R5 push", 0, 0, 0, 1, 0, 0, 0, 0);
        step("R5 push", 0, 0, 0, 1, 0, 0, 0, 0);
        step("R6 pop", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R6 pop", 0, 0, 0, 0, 1, 0, 0, 0);
        // R7: both strobes, with and without request
        step("R7 both no req", 0, 0, 0, 1, 1, 0, 0, 0);
        step("R7 both with req", 1, 2'b00, 16'h0042, 1, 1, 0, 0, 0);
        step("R7 pointer kept", 0, 0, 0, 0, 1, 0, 0, 0);
        step("R10 pop wrap", 0, 0, 0, 0, 1, 0, 0, 0);
        // R8: stack beats request
        step("R8 push over req", 1, 2'b01, 16'h7777, 1, 0, 0, 0, 0);
        step("R8 pop over req", 1, 2'b11, 16'h7777, 0, 1, 0, 0, 0);
        step("R11 idle after", 0, 0, 0, 0, 0, 0, 0, 0);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            step("R2 random", r[0], 2'(r[3:2]), 16'($urandom), r[4] & r[5], r[6] & r[7],
                 r[8], 2'(r[10:9]), 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule